// File: doc/BRIEF.md
# Redundant Clock Source Selector

This block decides which of two hot-pluggable reference oscillators feeds the platform clock. Each oscillator provides two status lines: one saying that it is seated in its slot, and one saying that its output amplitude is within limits. The block passes both lines through a synchronizer and a stability filter. It then treats an oscillator as usable only when both lines are true. From the usable set it drives the select line of an external glitch-free clock multiplexer.

The active source is kept for as long as it stays usable. Selection does not revert: a source that comes back after repair only takes over when the active source later fails. When the active source drops out, the select moves to the other source if that one is usable. In every case the block latches an alarm that names the source that failed. The alarm holds until software pulses a clear input.

If neither source is usable, the block raises a no-clock flag and keeps the last select value. Each slot has a green indicator and a yellow indicator. Green means the oscillator is present and healthy. Yellow means it is present but its amplitude is bad. An empty slot shows neither, which lets a technician swap the faulty part while the system runs.

Top module: `clk_src_selector`

## Requirements
- R1: A source is usable only when its presence line and its amplitude-valid line are both high after qualification. A source that is present with bad amplitude, or absent with the amplitude line high, is never selected.
- R2: While reset is held and just after it, `mux_sel` is 0, `no_clock` is 1, `alarm_valid` is 0, and every LED output is 0.
- R3: When only one source is usable, and no source was active or the active one has failed, `mux_sel` moves to that usable source (0 or 1) and `no_clock` goes to 0.
- R4: When both sources are usable and no source is active, the held selection is kept. After reset the held selection is 0, so source 0 is preferred.
- R5: Selection is non-revertive. While the active source stays usable, `mux_sel` does not change, whatever happens on the other source.
- R6: When the active source stops being usable and the other one is usable, `mux_sel` switches to the other source. In the same cycle `alarm_valid` is set and `alarm_src` holds the index of the failed source.
- R7: When the active source fails and the other source is not usable, `no_clock` goes to 1, `mux_sel` keeps its value, and the alarm is raised naming the failed source. While neither source is usable, `no_clock` stays 1.
- R8: `alarm_valid` stays at 1 until a cycle in which `alarm_clear` is high and no new failure occurs; that cycle clears it. A new failure overwrites `alarm_src` with the index of the latest failed source.
- R9: LED bit i of `led_green` is high when source i is present and its amplitude is valid. LED bit i of `led_yellow` is high when source i is present and its amplitude is invalid. An absent source lights neither LED. All of this uses the qualified inputs.
- R10: Inputs pass through a synchronizer of `SYNC_STAGES` flops. A change in the synchronized pair of a source takes effect only after it has held steady for more than `qual_cycles` cycles. A shorter disturbance changes nothing at the outputs. No change appears earlier than `SYNC_STAGES + qual_cycles` cycles after the raw input moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_present | input | 2 | Bit i high when oscillator i is seated (asynchronous) |
| osc_amp_ok | input | 2 | Bit i high when oscillator i amplitude is valid (asynchronous) |
| qual_cycles | input | QUAL_W (8) | Number of stable cycles required before an input change is accepted |
| alarm_clear | input | 1 | Software pulse that clears the latched alarm |
| mux_sel | output | 1 | Select line for the glitch-free clock multiplexer |
| no_clock | output | 1 | High when no source is usable |
| alarm_valid | output | 1 | Latched failure alarm |
| alarm_src | output | 1 | Index of the most recently failed source |
| led_green | output | 2 | Per-source healthy indicator |
| led_yellow | output | 2 | Per-source faulty indicator |

## Verification
The bench drops the active source while the standby is healthy, and checks both the switch and the alarm identity. A design that switched without naming the failed source, or that named the survivor, would be caught here. It brings a repaired source back while the other is active to catch a design that reverts. It kills both sources to confirm that the select is held rather than moved to a dead source.

Directed cases probe the filter. A three-cycle amplitude dropout must leave the selection and the alarm untouched. The output must not move five cycles after a genuine change, which catches a missing synchronizer or a missing counter. Further cases check that a clear removes the alarm, and that a slot with bad amplitude lights yellow and never green.

// File: rtl/csel_pkg.sv
package csel_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } csel_state_e;

  // pick result: found flag and chosen index
  typedef struct packed {
    logic found;
    logic idx;
  } csel_pick_t;

  function automatic logic csel_usable(input logic pres, input logic amp);
    return pres & amp;
  endfunction

  // Keep the current index when usable, else fall to the other one
  function automatic csel_pick_t csel_pick(input logic [1:0] usable, input logic cur);
    csel_pick_t r;
    if (usable[cur]) begin
      r.found = 1'b1;
      r.idx   = cur;
    end else if (usable[~cur]) begin
      r.found = 1'b1;
      r.idx   = ~cur;
    end else begin
      r.found = 1'b0;
      r.idx   = cur;
    end
    return r;
  endfunction

endpackage

// File: rtl/csel_sync.sv
module csel_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else        stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/csel_qual.sv
module csel_qual #(
  parameter int QUAL_W = 8,
  parameter int W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [QUAL_W-1:0] limit,
  input  logic [W-1:0]      d,
  output logic [W-1:0]      q,
  output logic              accept_evt
);
  logic [QUAL_W-1:0] cnt;
  logic [W-1:0]      d_prev;
  logic              differs;
  logic              moved;

  assign differs    = (d != q);
  assign moved      = (d != d_prev);
  assign accept_evt = differs && !moved && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= '0;
      d_prev <= '0;
      cnt    <= '0;
    end else begin
      d_prev <= d;
      if (!differs || moved) begin
        cnt <= '0;
      end else if (accept_evt) begin
        q   <= d;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/csel_policy.sv
module csel_policy
  import csel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] usable,
  output logic       sel,
  output logic       running,
  output logic       fail_evt,
  output logic       fail_src
);
  csel_state_e state_q;
  csel_pick_t  pick;

  assign pick     = csel_pick(usable, sel);
  assign fail_evt = (state_q == ST_RUN) && !usable[sel];
  assign fail_src = sel;
  assign running  = (state_q == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel     <= 1'b0;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (fail_evt) begin
            sel     <= pick.idx;
            state_q <= pick.found ? ST_RUN : ST_IDLE;
          end
        end
        default: begin
          if (pick.found) begin
            sel     <= pick.idx;
            state_q <= ST_RUN;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/csel_status.sv
module csel_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fail_evt,
  input  logic       fail_src,
  input  logic       clear,
  input  logic [1:0] pres_q,
  input  logic [1:0] amp_q,
  output logic       alarm_valid,
  output logic       alarm_src,
  output logic [1:0] led_green,
  output logic [1:0] led_yellow
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_valid <= 1'b0;
      alarm_src   <= 1'b0;
    end else if (fail_evt) begin
      alarm_valid <= 1'b1;
      alarm_src   <= fail_src;
    end else if (clear) begin
      alarm_valid <= 1'b0;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_led
    assign led_green[i]  = pres_q[i] & amp_q[i];
    assign led_yellow[i] = pres_q[i] & ~amp_q[i];
  end
endmodule

// File: rtl/clk_src_selector.sv
module clk_src_selector
  import csel_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        osc_present,
  input  logic [1:0]        osc_amp_ok,
  input  logic [QUAL_W-1:0] qual_cycles,
  input  logic              alarm_clear,
  output logic              mux_sel,
  output logic              no_clock,
  output logic              alarm_valid,
  output logic              alarm_src,
  output logic [1:0]        led_green,
  output logic [1:0]        led_yellow
);
  localparam int NSRC = 2;
  localparam int PW   = 2;

  logic [NSRC-1:0] pres_q, amp_q, usable, accept_evt;
  logic            running, fail_evt, fail_src;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [PW-1:0] raw_pair, sync_pair, qual_pair;
    assign raw_pair = {osc_present[i], osc_amp_ok[i]};

    csel_sync #(.STAGES(SYNC_STAGES), .W(PW)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_pair), .q(sync_pair)
    );

    csel_qual #(.QUAL_W(QUAL_W), .W(PW)) u_qual (
      .clk(clk), .rst_n(rst_n), .limit(qual_cycles),
      .d(sync_pair), .q(qual_pair), .accept_evt(accept_evt[i])
    );

    assign pres_q[i] = qual_pair[1];
    assign amp_q[i]  = qual_pair[0];
    assign usable[i] = csel_usable(qual_pair[1], qual_pair[0]);
  end

  csel_policy u_policy (
    .clk(clk), .rst_n(rst_n), .usable(usable),
    .sel(mux_sel), .running(running),
    .fail_evt(fail_evt), .fail_src(fail_src)
  );

  assign no_clock = !running;

  csel_status u_status (
    .clk(clk), .rst_n(rst_n), .fail_evt(fail_evt), .fail_src(fail_src),
    .clear(alarm_clear), .pres_q(pres_q), .amp_q(amp_q),
    .alarm_valid(alarm_valid), .alarm_src(alarm_src),
    .led_green(led_green), .led_yellow(led_yellow)
  );
endmodule

// File: rtl/csel_checker.sv
module csel_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       mux_sel,
  input logic       no_clock,
  input logic       alarm_valid,
  input logic       alarm_src,
  input logic       alarm_clear,
  input logic [1:0] led_green
);
  logic [1:0] green_d;
  logic       sel_d;
  logic       init;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      green_d <= 2'b00;
      sel_d   <= 1'b0;
      init    <= 1'b0;
    end else begin
      green_d <= led_green;
      sel_d   <= mux_sel;
      init    <= 1'b1;
    end
  end

  // R1 / R3: an active selection was usable in the deciding cycle
  a_r3_active_was_usable: assert property (@(posedge clk) disable iff (!rst_n)
    (init && !no_clock) |-> green_d[mux_sel]);

  // R6: any move of the select while running carries an alarm on the old source
  a_r6_switch_alarms: assert property (@(posedge clk) disable iff (!rst_n)
    (init && !$past(no_clock) && (mux_sel != sel_d)) |-> (alarm_valid && alarm_src == sel_d));

  // R7: nothing usable means no clock
  a_r7_none_usable: assert property (@(posedge clk) disable iff (!rst_n)
    (init && green_d == 2'b00) |-> no_clock);

  // R8: alarm holds without a clear
  a_r8_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (init && $past(alarm_valid) && !$past(alarm_clear)) |-> alarm_valid);

  // R5: a usable active source is kept
  a_r5_non_revert: assert property (@(posedge clk) disable iff (!rst_n)
    (init && !$past(no_clock) && green_d[sel_d]) |-> (mux_sel == sel_d && !no_clock));
endmodule

bind clk_src_selector csel_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mux_sel(mux_sel), .no_clock(no_clock),
  .alarm_valid(alarm_valid), .alarm_src(alarm_src),
  .alarm_clear(alarm_clear), .led_green(led_green)
);

// File: tb/tb_clk_src_selector.sv
module tb_clk_src_selector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] osc_present = 2'b11;
  logic [1:0] osc_amp_ok  = 2'b11;
  logic [7:0] qual_cycles = 8'd6;
  logic       alarm_clear = 1'b0;
  logic       mux_sel, no_clock, alarm_valid, alarm_src;
  logic [1:0] led_green, led_yellow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic m_sel, m_run, m_alarm, m_src;

  always #2 clk = ~clk;

  clk_src_selector dut (
    .clk(clk), .rst_n(rst_n), .osc_present(osc_present), .osc_amp_ok(osc_amp_ok),
    .qual_cycles(qual_cycles), .alarm_clear(alarm_clear), .mux_sel(mux_sel),
    .no_clock(no_clock), .alarm_valid(alarm_valid), .alarm_src(alarm_src),
    .led_green(led_green), .led_yellow(led_yellow)
  );

  function automatic logic [1:0] exp_usable(input logic [1:0] p, input logic [1:0] a);
    return p & a;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_step(input logic [1:0] u);
    if (m_run && !u[m_sel]) begin
      m_alarm = 1'b1;
      m_src   = m_sel;
      if (u[~m_sel]) m_sel = ~m_sel;
      else           m_run = 1'b0;
    end else if (!m_run) begin
      if (u[m_sel]) m_run = 1'b1;
      else if (u[~m_sel]) begin
        m_sel = ~m_sel;
        m_run = 1'b1;
      end
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R3/R5/R6 sel"}, {7'd0, mux_sel}, {7'd0, m_sel});
    chk({tag, " R7 no_clock"}, {7'd0, no_clock}, {7'd0, ~m_run});
    chk({tag, " R8 alarm"}, {7'd0, alarm_valid}, {7'd0, m_alarm});
    if (m_alarm) chk({tag, " R6 alarm_src"}, {7'd0, alarm_src}, {7'd0, m_src});
    chk({tag, " R9 green"}, {6'd0, led_green}, {6'd0, osc_present & osc_amp_ok});
    chk({tag, " R1/R9 yellow"}, {6'd0, led_yellow}, {6'd0, osc_present & ~osc_amp_ok});
  endtask

  task automatic apply(input logic [1:0] p, input logic [1:0] a, input string tag);
    osc_present = p;
    osc_amp_ok  = a;
    wait_cyc(25);
    model_step(exp_usable(p, a));
    check_all(tag);
  endtask

  initial begin
    void'($urandom(32'd4242));
    m_sel = 0; m_run = 0; m_alarm = 0; m_src = 0;
    wait_cyc(3);
    // R2 reset state
    chk("R2 sel", {7'd0, mux_sel}, 8'd0);
    chk("R2 no_clock", {7'd0, no_clock}, 8'd1);
    chk("R2 alarm", {7'd0, alarm_valid}, 8'd0);
    chk("R2 leds", {4'd0, led_green, led_yellow}, 8'd0);
    rst_n = 1'b1;
    // R4: both usable after reset -> source 0
    apply(2'b11, 2'b11, "R4 both");
    // R10: short dropout on active is filtered
    osc_amp_ok = 2'b10;
    wait_cyc(3);
    osc_amp_ok = 2'b11;
    wait_cyc(25);
    check_all("R10 glitch");
    // R10: real change not visible too early
    osc_amp_ok = 2'b10;
    wait_cyc(5);
    chk("R10 early", {7'd0, mux_sel}, 8'd0);
    chk("R10 early alarm", {7'd0, alarm_valid}, 8'd0);
    wait_cyc(20);
    model_step(2'b10);
    check_all("R6 failover");
    // R5: repaired source 0 returns, no revert
    apply(2'b11, 2'b11, "R5 repair");
    // R8 clear
    alarm_clear = 1'b1;
    wait_cyc(1);
    alarm_clear = 1'b0;
    m_alarm = 1'b0;
    wait_cyc(1);
    check_all("R8 clear");
    // R7: both die
    apply(2'b11, 2'b00, "R7 none");
    apply(2'b00, 2'b11, "R1 absent amp_ok");
    // R3: only source 0 comes back
    apply(2'b01, 2'b01, "R3 single");
    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [1:0] p, a;
      p = 2'($urandom);
      a = 2'($urandom);
      if (($urandom % 5) == 0) begin
        alarm_clear = 1'b1;
        wait_cyc(1);
        alarm_clear = 1'b0;
        m_alarm = 1'b0;
      end
      apply(p, a, "rand");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule